// File: doc/BRIEF.md
# Time-Sliced Logic Self-Test Sequencer

This block runs a logic self-test in small numbered slices rather than in one long run. A 32-bit maximal-length pseudo-random generator feeds a set of scan chains one bit per chain on every shift cycle. The chain outputs are folded into a 32-bit signature register. Each slice applies a fixed number of patterns, each a burst of shift cycles followed by a single capture cycle, and then a final unload burst. A slice begins only while the external functional-idle window is open, for example in the gap between two video frames.

When a slice ends, the sequencer compares the accumulated signature with the expected value that software wrote into the table entry for that slice. It then checkpoints both the generator and the signature, so the next slice continues the same pseudo-random sequence. If the idle window closes part-way through a slice, the slice is abandoned. Both registers return to their checkpoints and the same slice is run again in the next window. A sticky failure flag is raised on the alarm output for the safety manager. Status reports the slice in progress, the first failing slice and completion.

Top module: `lbist_slicer`

## Requirements
- R1: After reset the status word reads zero, `scan_en` is low and `fail_alarm` is low.
- R2: An armed sequencer starts a slice only on a clock edge where `idle_win` is high. While `idle_win` stays low it shifts nothing (`scan_en` low) and the slice index does not move.
- R3: Each pattern drives `scan_en` high for SHIFT_LEN cycles and then low for one capture cycle. After PATS patterns come SHIFT_LEN more unload cycles with `scan_en` high. On every cycle with `scan_en` high, `scan_in[j]` is generator bit j and the generator advances as a Fibonacci shift with feedback taps at bits 31, 21, 1 and 0, shifting toward the MSB.
- R4: The signature starts at zero and the generator starts at SEED when a run is started. On each shift cycle except those of a slice's first pattern, the signature becomes its own taps-feedback shift XORed with `scan_out` placed in its low bits. Both registers carry over from one slice to the next, so the expected value for slice k covers slices 0 to k.
- R5: At the end of each slice the signature is compared with table entry k. A mismatch sets a sticky fail flag and records k as the failing slice, and only the first failure is recorded. A new start clears both.
- R6: `fail_alarm` always equals the sticky fail flag.
- R7: If `idle_win` falls during a slice, the slice is abandoned. The generator and signature return to their start-of-slice values, the slice index is unchanged, and the same slice runs again at the next window, so an interrupted run still ends without failure.
- R8: After the programmed number of slices the sequencer reports done, clears busy, shows that count as its slice index and stops shifting.
- R9: Starting with a slice count of zero reports done at once and shifts nothing.
- R10: Register map. Writing bit 0 = 1 at address 0 starts a run. Address 1 holds the slice count (read/write), and writes above MAX_SLICES saturate to MAX_SLICES. Address 2 is status: bit 0 busy, bit 1 done, bit 2 fail, bits 15:8 current slice index, bits 23:16 failing slice index. Address 4+k holds the expected signature for slice k.
- R11: Without a start, the slice index only holds or rises by one, once per completed slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational on address) |
| idle_win | input | 1 | Functional-idle window; slices run only while high |
| scan_en | output | 1 | Scan enable: high to shift, low to capture |
| scan_in | output | NCH | Serial data into each scan chain |
| scan_out | input | NCH | Serial data out of each scan chain |
| fail_alarm | output | 1 | Sticky signature-mismatch alarm for the safety manager |

## Verification
The hardest case to reach from the ports is a window that closes at an arbitrary point inside a slice. The abandon-and-retry path must then leave the generator and signature exactly where the slice began. If it does not, only a later signature comparison reveals the error. The bench sweeps the length of the first window cycle by cycle across a whole slice and beyond, closes it for a few cycles, and reopens it. It then requires the run to end with no failure, which only happens if every partial slice was fully undone. Expected signatures come from an arithmetic model of the generator, chains, capture logic and signature register in the bench.

// File: rtl/lbist_pkg.sv
// lbist_pkg: shared types and register offsets for the sliced self-test sequencer.
// Assumes: register addresses are at least 3 bits wide.
package lbist_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_SHIFT,
        ST_CAPT,
        ST_UNLD,
        ST_CHECK
    } seq_st_t;

    localparam int REG_CTRL   = 0;
    localparam int REG_COUNT  = 1;
    localparam int REG_STATUS = 2;
    localparam int REG_EXP    = 4;

    localparam int STAT_IDX_LSB  = 8;
    localparam int STAT_FIDX_LSB = 16;

endpackage

// File: rtl/lbist_fsr.sv
// lbist_fsr: feedback shift register with a checkpoint copy.
// Used as the pattern generator (HAS_DIN=0) or as the signature register
// (HAS_DIN=1, data XORed into the low bits on each step).
// Assumes: init has priority over restore, and restore over step/commit.
module lbist_fsr #(
    parameter int          W       = 32,
    parameter logic [W-1:0] TAPS   = 32'h8020_0003,
    parameter int          DIN_W   = 2,
    parameter bit          HAS_DIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [W-1:0]     init_val,
    input  logic             step,
    input  logic             restore,
    input  logic             commit,
    input  logic [DIN_W-1:0] din,
    output logic [W-1:0]     q
);

    logic [W-1:0] cur;
    logic [W-1:0] ckpt;
    logic [W-1:0] inj;
    logic [W-1:0] nxt;

    // Pick the data-injection variant.
    generate
        if (HAS_DIN) begin : g_din
            assign inj = {{(W-DIN_W){1'b0}}, din};
        end else begin : g_nodin
            logic unused_din;
            assign unused_din = ^din;
            assign inj = '0;
        end
    endgenerate

    // Next state: shift toward the MSB with XOR feedback, plus injected data.
    always_comb begin
        nxt = {cur[W-2:0], ^(cur & TAPS)} ^ inj;
    end

    // Working value and its checkpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= init_val;
            ckpt <= init_val;
        end else if (init) begin
            cur  <= init_val;
            ckpt <= init_val;
        end else if (restore) begin
            cur <= ckpt;
        end else begin
            if (step)   cur  <= nxt;
            if (commit) ckpt <= cur;
        end
    end

    assign q = cur;

    // R7: an abandoned slice returns the register to its checkpoint.
    p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !init) |=> (cur == $past(ckpt)));

    // R4: without init, restore or step the working value holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !restore && !step) |=> $stable(cur));

endmodule

// File: rtl/lbist_seq.sv
// lbist_seq: slice sequencer. Waits for the idle window, walks the shift,
// capture and unload phases, checks the signature and steps the slice index.
// Assumes: SHIFT_LEN >= 2, PATS >= 2, slice count <= MAX_SLICES.
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int SHIFT_LEN  = 4,
    parameter int PATS       = 3,
    parameter int MAX_SLICES = 4,
    parameter int IDX_W      = $clog2(MAX_SLICES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] slice_cnt,
    input  logic             idle_win,
    input  logic             sig_match,
    output logic             scan_en,
    output logic             sig_step,
    output logic             restore,
    output logic             commit,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [IDX_W-1:0] slice_idx,
    output logic [IDX_W-1:0] fail_idx
);

    localparam int BIT_W = $clog2(SHIFT_LEN);
    localparam int PAT_W = $clog2(PATS);

    seq_st_t          st;
    logic [BIT_W-1:0] bit_cnt;
    logic [PAT_W-1:0] pat_cnt;
    logic [IDX_W-1:0] cnt_q;
    logic             active;
    logic             abort;
    logic             last_bit;

    // Phase decode shared by the datapath controls.
    always_comb begin
        active   = (st == ST_SHIFT) || (st == ST_CAPT) || (st == ST_UNLD);
        abort    = active && !idle_win;
        last_bit = (bit_cnt == BIT_W'(SHIFT_LEN - 1));
        scan_en  = (st == ST_SHIFT) || (st == ST_UNLD);
        sig_step = ((st == ST_SHIFT) && (pat_cnt != '0)) || (st == ST_UNLD);
        restore  = abort;
        commit   = (st == ST_CHECK);
        busy     = (st != ST_OFF);
    end

    // Phase, counters, slice index and sticky result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_OFF;
            bit_cnt   <= '0;
            pat_cnt   <= '0;
            cnt_q     <= '0;
            slice_idx <= '0;
            fail_idx  <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else if (start) begin
            bit_cnt   <= '0;
            pat_cnt   <= '0;
            cnt_q     <= slice_cnt;
            slice_idx <= '0;
            fail_idx  <= '0;
            fail      <= 1'b0;
            done      <= (slice_cnt == '0);
            st        <= (slice_cnt == '0) ? ST_OFF : ST_WAIT;
        end else if (abort) begin
            bit_cnt <= '0;
            pat_cnt <= '0;
            st      <= ST_WAIT;
        end else begin
            case (st)
                ST_WAIT: if (idle_win) st <= ST_SHIFT;
                ST_SHIFT: begin
                    bit_cnt <= last_bit ? '0 : bit_cnt + BIT_W'(1);
                    if (last_bit) st <= ST_CAPT;
                end
                ST_CAPT: begin
                    if (pat_cnt == PAT_W'(PATS - 1)) begin
                        pat_cnt <= '0;
                        st      <= ST_UNLD;
                    end else begin
                        pat_cnt <= pat_cnt + PAT_W'(1);
                        st      <= ST_SHIFT;
                    end
                end
                ST_UNLD: begin
                    bit_cnt <= last_bit ? '0 : bit_cnt + BIT_W'(1);
                    if (last_bit) st <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!sig_match && !fail) begin
                        fail     <= 1'b1;
                        fail_idx <= slice_idx;
                    end
                    slice_idx <= slice_idx + IDX_W'(1);
                    if ((slice_idx + IDX_W'(1)) == cnt_q) begin
                        st   <= ST_OFF;
                        done <= 1'b1;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                default: st <= ST_OFF;
            endcase
        end
    end

    // R2: a closed window keeps an armed sequencer from shifting.
    p_gate_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !idle_win && !start) |=> !scan_en);

    // R3: capture lasts one cycle, then shifting resumes.
    p_capture_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPT && idle_win && !start) |=> scan_en);

    // R5: fail and its recorded index stay put until the next start.
    p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_idx)));

    // R7: abandoning a slice keeps the slice index.
    p_abort_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start) |=> $stable(slice_idx));

    // R8: a finished run is quiet.
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !busy));

    // R11: the slice index holds or rises by one.
    p_idx_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start) |=> ($stable(slice_idx) || (slice_idx == $past(slice_idx) + IDX_W'(1))));

endmodule

// File: rtl/lbist_slicer.sv
// lbist_slicer: top of the time-sliced logic self-test controller.
// Holds the register file (start, slice count, status, expected table),
// the pattern generator and the signature register, and the sequencer.
// Assumes: ADDR_W >= 3, MAX_SLICES fits the expected-table address range,
// NCH < W, status fields of 8 bits hold IDX_W.
module lbist_slicer
    import lbist_pkg::*;
#(
    parameter int           W          = 32,
    parameter int           NCH        = 2,
    parameter int           SHIFT_LEN  = 4,
    parameter int           PATS       = 3,
    parameter int           MAX_SLICES = 4,
    parameter int           ADDR_W     = 4,
    parameter logic [W-1:0] SEED       = 32'h0000_0001,
    parameter logic [W-1:0] TAPS       = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              idle_win,
    output logic              scan_en,
    output logic [NCH-1:0]    scan_in,
    input  logic [NCH-1:0]    scan_out,
    output logic              fail_alarm
);

    localparam int IDX_W = $clog2(MAX_SLICES + 1);

    logic [IDX_W-1:0] cnt_reg;
    logic [W-1:0]     exp_tab [MAX_SLICES];
    logic [W-1:0]     exp_sel;
    logic [W-1:0]     gen;
    logic [W-1:0]     sig;
    logic             start;
    logic             sig_step;
    logic             restore;
    logic             commit;
    logic             busy;
    logic             done;
    logic             fail;
    logic [IDX_W-1:0] slice_idx;
    logic [IDX_W-1:0] fail_idx;
    logic             unused_gen;

    // Start strobe decoded from a control write.
    assign start = reg_wr && (reg_addr == ADDR_W'(REG_CTRL)) && reg_wdata[0];

    // Slice count register, saturating at the table depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_reg <= '0;
        end else if (reg_wr && reg_addr == ADDR_W'(REG_COUNT)) begin
            cnt_reg <= (reg_wdata > W'(MAX_SLICES)) ? IDX_W'(MAX_SLICES)
                                                    : reg_wdata[IDX_W-1:0];
        end
    end

    // One expected-signature register per slice.
    generate
        for (genvar k = 0; k < MAX_SLICES; k++) begin : g_exp
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    exp_tab[k] <= '0;
                end else if (reg_wr && reg_addr == ADDR_W'(REG_EXP + k)) begin
                    exp_tab[k] <= reg_wdata;
                end
            end
        end
    endgenerate

    // Select the expected value for the running slice.
    always_comb begin
        exp_sel = '0;
        for (int k = 0; k < MAX_SLICES; k++) begin
            if (slice_idx == IDX_W'(k)) exp_sel = exp_tab[k];
        end
    end

    // Read mux over control, count, status and table.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_COUNT)) begin
            reg_rdata[IDX_W-1:0] = cnt_reg;
        end else if (reg_addr == ADDR_W'(REG_STATUS)) begin
            reg_rdata[0] = busy;
            reg_rdata[1] = done;
            reg_rdata[2] = fail;
            reg_rdata[STAT_IDX_LSB +: IDX_W]  = slice_idx;
            reg_rdata[STAT_FIDX_LSB +: IDX_W] = fail_idx;
        end
        for (int k = 0; k < MAX_SLICES; k++) begin
            if (reg_addr == ADDR_W'(REG_EXP + k)) reg_rdata = exp_tab[k];
        end
    end

    lbist_seq #(
        .SHIFT_LEN (SHIFT_LEN),
        .PATS      (PATS),
        .MAX_SLICES(MAX_SLICES),
        .IDX_W     (IDX_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .slice_cnt(cnt_reg),
        .idle_win (idle_win),
        .sig_match(sig == exp_sel),
        .scan_en  (scan_en),
        .sig_step (sig_step),
        .restore  (restore),
        .commit   (commit),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .slice_idx(slice_idx),
        .fail_idx (fail_idx)
    );

    lbist_fsr #(
        .W      (W),
        .TAPS   (TAPS),
        .DIN_W  (NCH),
        .HAS_DIN(1'b0)
    ) i_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start),
        .init_val(SEED),
        .step    (scan_en),
        .restore (restore),
        .commit  (commit),
        .din     ('0),
        .q       (gen)
    );

    lbist_fsr #(
        .W      (W),
        .TAPS   (TAPS),
        .DIN_W  (NCH),
        .HAS_DIN(1'b1)
    ) i_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start),
        .init_val('0),
        .step    (sig_step),
        .restore (restore),
        .commit  (commit),
        .din     (scan_out),
        .q       (sig)
    );

    assign scan_in    = gen[NCH-1:0];
    assign fail_alarm = fail;
    assign unused_gen = ^gen[W-1:NCH];

    // R6: the alarm pin follows the reported fail bit.
    p_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_alarm == reg_rdata[2] || reg_addr != ADDR_W'(REG_STATUS));

    // R9: a zero-slice start finishes without shifting.
    p_zero_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_reg == '0) |=> (done && !scan_en));

endmodule

// File: tb/test_lbist_slicer.sv
// Bench: scan chains and a small capture circuit as a fixture; expected
// signatures from an arithmetic model of generator, chains and signature.
module test_lbist_slicer;

    localparam int          W   = 32;
    localparam int          NCH = 2;
    localparam int          SL  = 4;
    localparam int          PATS = 3;
    localparam int          MAXS = 4;
    localparam logic [31:0] SEED = 32'h0000_0001;
    localparam logic [31:0] TAPS = 32'h8020_0003;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [3:0]     reg_addr = '0;
    logic [W-1:0]   reg_wdata = '0;
    logic [W-1:0]   reg_rdata;
    logic           idle_win = 1'b0;
    logic           scan_en;
    logic [NCH-1:0] scan_in;
    logic [NCH-1:0] scan_out;
    logic           fail_alarm;

    logic [SL-1:0]  ca, cb;
    logic [31:0]    exp_ref [MAXS];
    int             errs = 0;
    int             checks = 0;
    int             cyc = 0;
    bit             mon = 1'b0;
    int             hi_cnt = 0;
    int             rise_cnt = 0;
    logic           prev_en = 1'b0;

    always #10 clk = ~clk;

    lbist_slicer i_lbist_slicer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_win(idle_win),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .fail_alarm(fail_alarm)
    );

    function automatic logic [7:0] cut(input logic [3:0] a, input logic [3:0] b);
        return {a ^ {b[2:0], b[3]}, (a & b) ^ {a[0], a[3:1]} ^ 4'b0101};
    endfunction

    function automatic logic [31:0] fstep(input logic [31:0] s, input logic [1:0] d);
        return {s[30:0], ^(s & TAPS)} ^ {30'b0, d};
    endfunction

    // Fixture: two scan chains, shift when enabled, capture otherwise.
    assign scan_out = {cb[SL-1], ca[SL-1]};
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca <= '0; cb <= '0;
        end else if (scan_en) begin
            ca <= {ca[SL-2:0], scan_in[0]};
            cb <= {cb[SL-2:0], scan_in[1]};
        end else begin
            {cb, ca} <= cut(ca, cb);
        end
    end

    // Shift activity monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon) begin
            if (scan_en) hi_cnt++;
            if (scan_en && !prev_en) rise_cnt++;
        end
        prev_en = scan_en;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] st);
        for (int i = 0; i < 3000; i++) begin
            rd(2, st);
            if (st[1]) break;
        end
    endtask

    // Program the table (with corrupted entries where mask bits are set), count, start.
    task automatic arm(input int n, input logic [3:0] bad);
        for (int k = 0; k < MAXS; k++) wr(4 + k, exp_ref[k] ^ {31'b0, bad[k]});
        wr(1, n);
        wr(0, 1);
    endtask

    initial begin
        logic [31:0] g, s, v, st;
        logic [3:0]  a, b;
        g = SEED; s = '0; a = '0; b = '0;
        for (int k = 0; k < MAXS; k++) begin
            for (int p = 0; p < PATS; p++) begin
                for (int i = 0; i < SL; i++) begin
                    if (p != 0) s = fstep(s, {b[3], a[3]});
                    a = {a[2:0], g[0]}; b = {b[2:0], g[1]};
                    g = fstep(g, 2'b00);
                end
                {b, a} = cut(a, b);
            end
            for (int i = 0; i < SL; i++) begin
                s = fstep(s, {b[3], a[3]});
                a = {a[2:0], g[0]}; b = {b[2:0], g[1]};
                g = fstep(g, 2'b00);
            end
            exp_ref[k] = s;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(2, v);
        chk("R1 status after reset", v, 32'h0);
        chk("R1 scan_en after reset", {31'b0, scan_en}, 32'h0);
        chk("R1 alarm after reset", {31'b0, fail_alarm}, 32'h0);

        // R10: register map readback and count saturation.
        wr(1, 7);
        rd(1, v);
        chk("R10 count saturates", v, 32'd4);
        wr(1, 3);
        rd(1, v);
        chk("R10 count readback", v, 32'd3);
        for (int k = 0; k < MAXS; k++) begin
            wr(4 + k, 32'hA5A5_0000 + k);
            rd(4 + k, v);
            chk("R10 expected table readback", v, 32'hA5A5_0000 + k);
        end

        // R9: zero slices finish at once.
        wr(1, 0);
        wr(0, 1);
        rd(2, v);
        chk("R9 zero-slice done, not busy", v & 32'h7, 32'h2);
        chk("R9 no shifting", {31'b0, scan_en}, 32'h0);

        // R2: armed but window closed -> nothing happens.
        arm(3, 4'b0000);
        mon = 1'b1; hi_cnt = 0; rise_cnt = 0;
        repeat (40) @(negedge clk);
        rd(2, v);
        chk("R2 closed window: no shift cycles", hi_cnt, 0);
        chk("R2 closed window: busy, index 0", v, 32'h1);

        // R3, R4, R8: uninterrupted run of three slices.
        idle_win = 1'b1;
        wait_done(st);
        mon = 1'b0;
        chk("R4 cumulative signatures match, no fail", {29'b0, st[2:0]}, 32'h2);
        chk("R8 index equals count when done", {24'b0, st[15:8]}, 32'd3);
        chk("R3 shift cycles per three slices", hi_cnt, 3 * (PATS + 1) * SL);
        chk("R3 shift bursts per three slices", rise_cnt, 3 * (PATS + 1));
        repeat (5) @(negedge clk);
        chk("R8 quiet after done", {31'b0, scan_en}, 32'h0);

        // R5, R6: corrupted entries 1 and 2 -> first failure recorded.
        arm(3, 4'b0110);
        wait_done(st);
        chk("R5 fail set", {31'b0, st[2]}, 32'h1);
        chk("R5 first failing slice", {24'b0, st[23:16]}, 32'd1);
        chk("R6 alarm follows fail", {31'b0, fail_alarm}, 32'h1);
        wr(0, 1);
        rd(2, v);
        chk("R5 start clears fail", {31'b0, v[2]}, 32'h0);
        chk("R6 alarm cleared by start", {31'b0, fail_alarm}, 32'h0);
        wait_done(st);
        chk("R5 fail stays set past later mismatch", {24'b0, st[23:16]}, 32'd1);

        // R7: interrupt slice 1 mid-way, check index held, then finish cleanly.
        idle_win = 1'b0;
        arm(3, 4'b0000);
        idle_win = 1'b1;
        repeat (30) @(negedge clk);
        idle_win = 1'b0;
        repeat (3) @(negedge clk);
        rd(2, v);
        chk("R7 index held after abandon", {24'b0, v[15:8]}, 32'd1);
        chk("R7 no shifting while window closed", {31'b0, scan_en}, 32'h0);
        idle_win = 1'b1;
        wait_done(st);
        chk("R7 retried run passes", {29'b0, st[2:0]}, 32'h2);

        // R7 sweep: close the window after every possible first-window length.
        for (int len = 1; len <= 24; len++) begin
            idle_win = 1'b0;
            arm(2, 4'b0000);
            idle_win = 1'b1;
            repeat (len) @(negedge clk);
            idle_win = 1'b0;
            repeat (3) @(negedge clk);
            idle_win = 1'b1;
            wait_done(st);
            chk("R7 sweep: retry leaves no fail", {29'b0, st[2:0]}, 32'h2);
        end

        // R8, R11: every slice count with windows that fit one slice each.
        for (int n = 1; n <= MAXS; n++) begin
            idle_win = 1'b0;
            arm(n, 4'b0000);
            for (int k = 0; k < n; k++) begin
                idle_win = 1'b1;
                repeat (22) @(negedge clk);
                idle_win = 1'b0;
                rd(2, v);
                chk("R11 index steps once per window", {24'b0, v[15:8]}, k + 1);
            end
            rd(2, v);
            chk("R8 done, no fail for count", {29'b0, v[2:0]}, 32'h2);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule